// File: doc/BRIEF.md
# Triggered Conversion List Sequencer

This block steps through a fixed list of analog channel numbers, one entry per hardware trigger. When a trigger arrives and no conversion is in flight, it asks an external one-shot converter to convert the channel held in the current list slot. It holds that request until the converter answers with a done strobe and a result, then stores the result in a small first-in first-out store. After the last slot the list pointer returns to slot 0, so repeated triggers cycle through the list.

Every accepted trigger produces a one-cycle pulse. A separate watermark output goes high while the number of stored results is strictly greater than a threshold input. For a list of N channels, a threshold of N-1 therefore signals once per full pass. A reader pops results in the order they were converted. Two sticky flags record lost events. One flags a trigger that arrived while a conversion was still pending. The other flags a result that arrived when the store was already full.

Top module: `convlist_seq`

## Requirements
- R1: A trigger sampled high while no conversion is pending is accepted. In the next cycle `conv_req_o` is high, `conv_ch_o` carries the channel of the current list slot, and `trig_pulse_o` is high for exactly that one cycle.
- R2: Slot i of the list occupies bits [i*CH_W +: CH_W] of `list_chs_i`. Accepted triggers use slots 0, 1, … in order and wrap to slot 0 after slot LIST_LEN-1. `conv_ch_o` stays constant while a request is held.
- R3: `conv_req_o` stays high until `conv_done_i` is sampled high. In the following cycle the request is low and the stored result count has risen by one.
- R4: A trigger sampled while a conversion is pending is dropped. It gives no pulse and does not advance the list, and it sets `overrun_o`, which stays high until reset.
- R5: `rd_data_o` shows the oldest stored result. A cycle with `rd_en_i` high removes that result. Results leave in the order they were converted.
- R6: `wm_irq_o` is high exactly when `fifo_level_o` is strictly greater than `wm_thresh_i`. It is low when the two are equal.
- R7: A result that arrives while the store holds FIFO_DEPTH entries is discarded. The stored entries stay as they were, and `overflow_o` is set and stays high until reset.
- R8: While the store is empty, `rd_data_o` is zero. A read of an empty store leaves the level at zero.
- R9: During and directly after reset, every output is zero and the list pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Hardware trigger, sampled each cycle |
| list_chs_i | input | LIST_LEN*CH_W | Channel list, slot i at bits [i*CH_W +: CH_W] |
| wm_thresh_i | input | LVL_W | Watermark threshold |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | CH_W | Channel to convert |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | RES_W | Conversion result, valid with done |
| rd_en_i | input | 1 | Pop the oldest result |
| rd_data_o | output | RES_W | Oldest stored result, zero when empty |
| fifo_level_o | output | LVL_W | Number of stored results |
| trig_pulse_o | output | 1 | One-cycle pulse per accepted trigger |
| wm_irq_o | output | 1 | Level strictly above threshold |
| overrun_o | output | 1 | Sticky: trigger dropped while busy |
| overflow_o | output | 1 | Sticky: result dropped while full |

## Verification
The assertions take for granted that the converter raises `conv_done_i` only while `conv_req_o` is high, as a single-cycle strobe, and that `list_chs_i` stays constant after reset. The stimulus keeps to this. The bench's converter model raises done only while its own copy of the pending state is set. It then clears that state at once, so no done strobe follows a completed conversion. The list is written before reset is released and is never changed afterwards. Triggers, reads and the threshold are still driven freely, so triggers land while a conversion is pending and reads land on an empty store.

// File: rtl/convlist_pkg.sv
package convlist_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/convlist_ctrl.sv
module convlist_ctrl
  import convlist_pkg::*;
#(
  parameter int LIST_LEN = 3,
  parameter int CH_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_i,
  input  logic [LIST_LEN*CH_W-1:0] list_chs_i,
  input  logic                     conv_done_i,
  output logic                     conv_req_o,
  output logic [CH_W-1:0]          conv_ch_o,
  output logic                     trig_pulse_o,
  output logic                     overrun_o,
  output logic                     push_o
);
  localparam int PTR_W = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(LIST_LEN - 1);

  logic [CH_W-1:0] slot_ch [LIST_LEN];

  genvar gi;
  generate
    for (gi = 0; gi < LIST_LEN; gi++) begin : g_slot
      assign slot_ch[gi] = list_chs_i[gi*CH_W +: CH_W];
    end
  endgenerate

  seq_state_e      state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic             pulse_q, pulse_d;
  logic             ovr_q, ovr_d;
  logic             accept;
  logic             finish;

  always_comb begin
    accept  = trig_i && (state_q == SEQ_IDLE);
    finish  = conv_done_i && (state_q == SEQ_BUSY);
    state_d = state_q;
    ptr_d   = ptr_q;
    ch_d    = ch_q;
    pulse_d = accept;
    ovr_d   = ovr_q || (trig_i && (state_q == SEQ_BUSY));
    if (accept) begin
      state_d = SEQ_BUSY;
      ch_d    = slot_ch[ptr_q];
      ptr_d   = (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
    end else if (finish) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
      ch_q    <= '0;
      pulse_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      pulse_q <= pulse_d;
      ovr_q   <= ovr_d;
      if (accept) ch_q <= ch_d;
    end
  end

  assign conv_req_o   = (state_q == SEQ_BUSY);
  assign conv_ch_o    = ch_q;
  assign trig_pulse_o = pulse_q;
  assign overrun_o    = ovr_q;
  assign push_o       = finish;
endmodule

// File: rtl/convlist_fifo.sv
module convlist_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              overflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              do_push, do_pop;

  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    do_push = push_i && (cnt_q != FULL_LVL);
    ovf_d   = ovf_q || (push_i && (cnt_q == FULL_LVL));
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata_i;
  end

  assign rdata_o    = (cnt_q != '0) ? mem[rd_q] : '0;
  assign level_o    = cnt_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/convlist_seq.sv
module convlist_seq #(
  parameter int LIST_LEN   = 3,
  parameter int CH_W       = 6,
  parameter int RES_W      = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_i,
  input  logic [LIST_LEN*CH_W-1:0] list_chs_i,
  input  logic [LVL_W-1:0]         wm_thresh_i,
  output logic                     conv_req_o,
  output logic [CH_W-1:0]          conv_ch_o,
  input  logic                     conv_done_i,
  input  logic [RES_W-1:0]         conv_data_i,
  input  logic                     rd_en_i,
  output logic [RES_W-1:0]         rd_data_o,
  output logic [LVL_W-1:0]         fifo_level_o,
  output logic                     trig_pulse_o,
  output logic                     wm_irq_o,
  output logic                     overrun_o,
  output logic                     overflow_o
);
  logic push;

  convlist_ctrl #(
    .LIST_LEN (LIST_LEN),
    .CH_W     (CH_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .list_chs_i   (list_chs_i),
    .conv_done_i  (conv_done_i),
    .conv_req_o   (conv_req_o),
    .conv_ch_o    (conv_ch_o),
    .trig_pulse_o (trig_pulse_o),
    .overrun_o    (overrun_o),
    .push_o       (push)
  );

  convlist_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (RES_W)
  ) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .wdata_i    (conv_data_i),
    .pop_i      (rd_en_i),
    .rdata_o    (rd_data_o),
    .level_o    (fifo_level_o),
    .overflow_o (overflow_o)
  );

  // strict comparison: equal level does not notify
  assign wm_irq_o = (fifo_level_o > wm_thresh_i);
endmodule

// File: rtl/convlist_seq_chk.sv
module convlist_seq_chk #(
  parameter int CH_W       = 6,
  parameter int RES_W      = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             conv_req_o,
  input logic [CH_W-1:0]  conv_ch_o,
  input logic             conv_done_i,
  input logic             rd_en_i,
  input logic [RES_W-1:0] rd_data_o,
  input logic [LVL_W-1:0] fifo_level_o,
  input logic             trig_pulse_o,
  input logic             overrun_o,
  input logic             overflow_o
);
  a_r1_pulse_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse_o |-> conv_req_o);

  a_r2_ch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_done_i) |=> $stable(conv_ch_o));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_done_i) |=> conv_req_o);

  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && conv_done_i) |=> !conv_req_o);

  a_r4_busy_trig_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && trig_i) |=> (overrun_o && !trig_pulse_o));

  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level_o <= LVL_W'(FIFO_DEPTH));

  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level_o == '0) |-> (rd_data_o == '0));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (fifo_level_o == '0) && !(conv_req_o && conv_done_i))
      |=> (fifo_level_o == '0));
endmodule

bind convlist_seq convlist_seq_chk #(
  .CH_W       (CH_W),
  .RES_W      (RES_W),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .conv_req_o   (conv_req_o),
  .conv_ch_o    (conv_ch_o),
  .conv_done_i  (conv_done_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .fifo_level_o (fifo_level_o),
  .trig_pulse_o (trig_pulse_o),
  .overrun_o    (overrun_o),
  .overflow_o   (overflow_o)
);

// File: tb/convlist_seq_test.sv
`timescale 1ns/1ps
module convlist_seq_test;
  localparam int LIST_LEN = 3;
  localparam int CH_W     = 6;
  localparam int RES_W    = 12;
  localparam int DEPTH    = 4;
  localparam int LVL_W    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic trig_i, conv_done_i, rd_en_i;
  logic [LIST_LEN*CH_W-1:0] list_chs_i;
  logic [LVL_W-1:0] wm_thresh_i;
  logic [RES_W-1:0] conv_data_i;
  logic conv_req_o, trig_pulse_o, wm_irq_o, overrun_o, overflow_o;
  logic [CH_W-1:0] conv_ch_o;
  logic [RES_W-1:0] rd_data_o;
  logic [LVL_W-1:0] fifo_level_o;

  always #2.5 clk = ~clk;

  convlist_seq #(
    .LIST_LEN(LIST_LEN), .CH_W(CH_W), .RES_W(RES_W), .FIFO_DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .list_chs_i(list_chs_i),
    .wm_thresh_i(wm_thresh_i), .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .fifo_level_o(fifo_level_o),
    .trig_pulse_o(trig_pulse_o), .wm_irq_o(wm_irq_o),
    .overrun_o(overrun_o), .overflow_o(overflow_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model
  int lst [LIST_LEN] = '{48, 54, 55};
  int m_ptr;
  bit m_pend, m_pulse, m_ovr, m_ovf;
  int m_ch;
  logic [RES_W-1:0] m_q [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz;
    longint exp_rd;
    sz = m_q.size();
    exp_rd = (sz > 0) ? longint'(m_q[0]) : 0;
    chk(conv_req_o == m_pend, "R3", "conv_req_o", conv_req_o, m_pend);
    if (m_pend) chk(conv_ch_o == CH_W'(m_ch), "R2", "conv_ch_o", conv_ch_o, m_ch);
    chk(trig_pulse_o == m_pulse, "R1", "trig_pulse_o", trig_pulse_o, m_pulse);
    chk(fifo_level_o == LVL_W'(sz), "R5", "fifo_level_o", fifo_level_o, sz);
    chk(rd_data_o == RES_W'(exp_rd), (sz > 0) ? "R5" : "R8", "rd_data_o",
        rd_data_o, exp_rd);
    chk(wm_irq_o == (sz > int'(wm_thresh_i)), "R6", "wm_irq_o", wm_irq_o,
        sz > int'(wm_thresh_i));
    chk(overrun_o == m_ovr, "R4", "overrun_o", overrun_o, m_ovr);
    chk(overflow_o == m_ovf, "R7", "overflow_o", overflow_o, m_ovf);
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic step(input bit t, input bit d, input logic [RES_W-1:0] dat,
                      input bit r);
    int sz;
    bit push;
    sz = m_q.size();
    trig_i = t; conv_done_i = d; conv_data_i = dat; rd_en_i = r;
    m_pulse = t && !m_pend;
    if (t && m_pend) m_ovr = 1'b1;
    push = d && m_pend;
    if (r && sz > 0) void'(m_q.pop_front());
    if (push) begin
      if (sz < DEPTH) m_q.push_back(dat);
      else m_ovf = 1'b1;
    end
    if (m_pulse) begin
      m_pend = 1'b1;
      m_ch   = lst[m_ptr];
      m_ptr  = (m_ptr == LIST_LEN - 1) ? 0 : m_ptr + 1;
    end else if (push) begin
      m_pend = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    trig_i = 1'b0; conv_done_i = 1'b0; rd_en_i = 1'b0;
    compare_all();
  endtask

  task automatic convert(input logic [RES_W-1:0] dat);
    step(1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b0);
    step(1'b0, 1'b1, dat, 1'b0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    trig_i = 1'b0; conv_done_i = 1'b0; rd_en_i = 1'b0; conv_data_i = '0;
    list_chs_i = {CH_W'(55), CH_W'(54), CH_W'(48)};
    wm_thresh_i = LVL_W'(2);
    m_ptr = 0; m_pend = 0; m_pulse = 0; m_ovr = 0; m_ovf = 0; m_ch = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!conv_req_o && !trig_pulse_o && !wm_irq_o && !overrun_o && !overflow_o
        && fifo_level_o == '0 && rd_data_o == '0, "R9", "outputs in reset",
        {conv_req_o, trig_pulse_o, wm_irq_o, overrun_o, overflow_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R6: threshold 2 with three entries -> notify after the third result
    convert(12'h111);
    convert(12'h222);
    chk(!wm_irq_o, "R6", "wm at level 2 thr 2", wm_irq_o, 0);
    convert(12'h333);
    chk(wm_irq_o, "R6", "wm at level 3 thr 2", wm_irq_o, 1);
    // R5: drain in order
    step(0, 0, '0, 1); step(0, 0, '0, 1); step(0, 0, '0, 1);
    // R6: threshold 3 -> only the fourth result notifies; R2 wrap 55 -> 48
    wm_thresh_i = LVL_W'(3);
    convert(12'h0A1); convert(12'h0A2); convert(12'h0A3);
    chk(!wm_irq_o, "R6", "wm at level 3 thr 3", wm_irq_o, 0);
    convert(12'h0A4);
    chk(wm_irq_o, "R6", "wm at level 4 thr 3", wm_irq_o, 1);
    // R4: trigger while pending
    step(1, 0, '0, 0);
    step(1, 0, '0, 0);
    chk(overrun_o && !trig_pulse_o, "R4", "dropped trigger", overrun_o, 1);
    // R7: result into full store
    step(0, 1, 12'hFFF, 0);
    chk(overflow_o && fifo_level_o == LVL_W'(DEPTH), "R7", "overflow",
        fifo_level_o, DEPTH);
    repeat (DEPTH) step(0, 0, '0, 1);
    // R8: reads of an empty store
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);
    chk(fifo_level_o == '0 && rd_data_o == '0, "R8", "empty read",
        rd_data_o, 0);

    // R1 R2 R3 R5 R6: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit t, d, r;
      if (i % 500 == 0) wm_thresh_i = LVL_W'($urandom_range(0, DEPTH));
      t = ($urandom_range(0, 2) == 0);
      d = m_pend && ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 3) == 0);
      step(t, d, RES_W'($urandom()), r);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule